// File: doc/BRIEF.md
# Constant-Modulus Two-Adder Sum Unit

This block adds two residues `x` and `y`, each already reduced into the range 0 to m-1, and returns their sum reduced modulo a fixed modulus m. The modulus is an elaboration-time parameter that is not a power of two. The operand and result width K is derived from it as the smallest width with 2^(K-1) < m < 2^K.

The reduction uses no comparator against m and no lookup table. A first carry-propagate adder forms the raw sum with a carry-out. A second adder adds the constant 2^K - m to the low K bits of that sum, also with a carry-out. A 2:1 multiplexer picks the corrected sum whenever either carry is set, and the uncorrected low bits otherwise. A parameter selects one of two forms:
- a purely combinational path;
- a single output register, with a valid flag that lags the input flag by one cycle.

Top module: `modAdder`

## Requirements
- R1: When x + y < m, a valid result equals x + y.
- R2: When x + y >= m, a valid result equals x + y - m.
- R3: Operand and result ports are K bits wide, with 2^(K-1) < m < 2^K (K = 4 for m = 13, K = 3 for m = 5).
- R4: Every valid result lies in the range 0 to m-1.
- R5: With the output register enabled, the result for a pair presented with `inValid` high appears, with `outValid` high, exactly one clock later.
- R6: With the output register enabled, `sum` keeps its last value in any cycle that follows a cycle in which `inValid` was low.
- R7: With the output register disabled, `outValid` equals `inValid` and `sum` reflects the current operands in the same cycle.
- R8: While reset (`rstN` low, asynchronous, active low) is applied, the registered form drives `outValid` = 0 and `sum` = 0.
- R9: The boundary pairs (0,0), (m-1,m-1) and a pair whose sum equals m give 0, m-2 and 0 respectively.
- R10: The carry-outs of the two adders are never both set for in-range operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the registered form) |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands are valid this cycle |
| x | input | K | First residue, 0 to m-1 |
| y | input | K | Second residue, 0 to m-1 |
| outValid | output | 1 | `sum` holds a valid result |
| sum | output | K | (x + y) mod m |

## Verification
The bench builds two copies of the block.

The first copy uses m = 13 with the output register enabled. It is driven with all 169 operand pairs, with idle cycles between them. Every carry combination, the one-cycle latency and the hold behaviour are therefore exercised.

The second copy uses m = 5 without the register. It is swept over all 25 pairs, so the combinational form and a small odd width are checked exhaustively as well.

// File: rtl/mod_adder_pkg.sv
package mod_adder_pkg;
  typedef struct packed {
    logic load;
  } maddStrobe_t;
endpackage

// File: rtl/mod_adder_ctrl.sv
module mod_adder_ctrl
  import mod_adder_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output maddStrobe_t strobe,
  output logic        outValid
);
  assign strobe.load = inValid;

  generate
    if (REG_OUT) begin : g_reg
      logic validQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= inValid;
      end
      assign outValid = validQ;

      // R5
      valid_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
        outValid == $past(inValid));
    end else begin : g_comb
      assign outValid = inValid;
    end
  endgenerate
endmodule

// File: rtl/mod_adder_dp.sv
module mod_adder_dp
  import mod_adder_pkg::*;
#(
  parameter int MODULUS = 13,
  parameter bit REG_OUT = 1'b1,
  localparam int K = $clog2(MODULUS)
) (
  input  logic         clk,
  input  logic         rstN,
  input  maddStrobe_t  strobe,
  input  logic [K-1:0] x,
  input  logic [K-1:0] y,
  output logic [K-1:0] sum
);
  localparam logic [K:0] CORR = (K+1)'((2 ** K) - MODULUS);

  logic [K:0]   rawSum;
  logic [K:0]   fixSum;
  logic         useFix;
  logic [K-1:0] nextSum;

  assign rawSum  = {1'b0, x} + {1'b0, y};
  assign fixSum  = {1'b0, rawSum[K-1:0]} + CORR;
  assign useFix  = rawSum[K] | fixSum[K];
  assign nextSum = useFix ? fixSum[K-1:0] : rawSum[K-1:0];

  // R10
  carry_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> !(rawSum[K] && fixSum[K]));

  generate
    if (REG_OUT) begin : g_reg
      logic [K-1:0] sumQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            sumQ <= '0;
        else if (strobe.load) sumQ <= nextSum;
      end
      assign sum = sumQ;

      // R6
      hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        !$past(strobe.load) |-> $stable(sum));
    end else begin : g_comb
      assign sum = nextSum;

      // R1 R2
      comb_value_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobe.load |-> (int'(sum) == (int'(x) + int'(y)) % MODULUS));
    end
  endgenerate
endmodule

// File: rtl/modAdder.sv
module modAdder
  import mod_adder_pkg::*;
#(
  parameter int MODULUS = 13,
  parameter bit REG_OUT = 1'b1,
  localparam int K = $clog2(MODULUS)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [K-1:0] x,
  input  logic [K-1:0] y,
  output logic         outValid,
  output logic [K-1:0] sum
);
  maddStrobe_t strobe;

  mod_adder_ctrl #(.REG_OUT(REG_OUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  mod_adder_dp #(.MODULUS(MODULUS), .REG_OUT(REG_OUT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .x(x), .y(y), .sum(sum)
  );

  // R4
  range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (int'(sum) < MODULUS));
endmodule

// File: tb/modAdder_bench.sv
module modAdder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int M_A = 13;
  localparam int K_A = $clog2(M_A);
  localparam int M_B = 5;
  localparam int K_B = $clog2(M_B);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [K_A-1:0] x = '0, y = '0;
  logic outValid;
  logic [K_A-1:0] sum;

  logic inValidB = 1'b0;
  logic [K_B-1:0] xb = '0, yb = '0;
  logic outValidB;
  logic [K_B-1:0] sumB;

  int checks = 0;
  int failures = 0;
  int expQ[$];
  int tagQ[$];
  int lastSum = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modAdder #(.MODULUS(M_A), .REG_OUT(1'b1)) u_modAdder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .x(x), .y(y),
    .outValid(outValid), .sum(sum));

  modAdder #(.MODULUS(M_B), .REG_OUT(1'b0)) u_modAdder_comb (
    .clk(clk), .rstN(rstN), .inValid(inValidB), .x(xb), .y(yb),
    .outValid(outValidB), .sum(sumB));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int a, input int b);
    int tag;
    @(negedge clk);
    inValid = 1'b1;
    x = K_A'(a);
    y = K_A'(b);
    if ((a == 0 && b == 0) || (a == M_A-1 && b == M_A-1) || (a + b == M_A)) tag = 9;
    else if (a + b < M_A) tag = 1;
    else tag = 2;
    expQ.push_back((a + b) % M_A);
    tagQ.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rstN) begin
        if (outValid) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R5 unexpected outValid", 1, 0);
          end else begin
            int e, t;
            e = expQ.pop_front();
            t = tagQ.pop_front();
            if (t == 9)      check(int'(sum) == e, "R9", int'(sum), e);
            else if (t == 1) check(int'(sum) == e, "R1", int'(sum), e);
            else             check(int'(sum) == e, "R2", int'(sum), e);
            check(int'(sum) < M_A, "R4", int'(sum), M_A - 1);
          end
          lastSum = int'(sum);
        end else begin
          check(int'(sum) == lastSum, "R6 hold", int'(sum), lastSum);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R3 width checks
    check($bits(sum) == 4, "R3", $bits(sum), 4);
    check($bits(sumB) == 3, "R3", $bits(sumB), 3);
    repeat (3) @(negedge clk);
    // R8 reset state
    check(outValid == 1'b0, "R8 outValid", int'(outValid), 0);
    check(sum == '0, "R8 sum", int'(sum), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R9 boundaries first, then full sweep with idle gaps (R5, R6)
    send(0, 0);
    send(M_A-1, M_A-1);
    send(6, 7);
    idle();
    idle();
    for (int a = 0; a < M_A; a++) begin
      for (int b = 0; b < M_A; b++) begin
        send(a, b);
        if ((a + b) % 5 == 0) idle();
      end
    end
    idle();
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R5 drained", expQ.size(), 0);

    // R7 combinational form, exhaustive for m = 5
    for (int a = 0; a < M_B; a++) begin
      for (int b = 0; b < M_B; b++) begin
        @(negedge clk);
        inValidB = 1'b1;
        xb = K_B'(a);
        yb = K_B'(b);
        #1;
        check(outValidB == 1'b1, "R7 outValid", int'(outValidB), 1);
        if (a + b < M_B) check(int'(sumB) == a + b, "R1 R7", int'(sumB), a + b);
        else check(int'(sumB) == a + b - M_B, "R2 R7", int'(sumB), a + b - M_B);
      end
    end
    @(negedge clk);
    inValidB = 1'b0;
    #1;
    check(outValidB == 1'b0, "R7 idle", int'(outValidB), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule